// File: doc/BRIEF.md
# GPIO Port with Edge Detection

A 28-pin general-purpose I/O port controlled through a simple word-addressed register port. Each pin has a direction bit that turns its output driver on, and an output latch that changes only through two write-only strobe registers: one sets bits and one clears them. Every input pin passes through a two-stage synchroniser, and the synchronised levels can be read back as a word.

Each pin has its own rising-edge and falling-edge enable. An enabled edge on the synchronised input latches a sticky status bit, which software clears by writing a 1 to it. The status bits of pins 0 to 7 can be steered one by one to a dedicated interrupt line. Every status bit that is not steered to a dedicated line is ORed into one summary interrupt, which stays high as long as any such bit is still set.

Registers are 32 bits wide. The register map uses word addresses: 0 levels (read only), 1 output latch readback (read only), 2 set strobe, 3 clear strobe, 4 direction, 5 rising enable, 6 falling enable, 7 edge status, 8 routing.

Top module: `gpio_edge_port`

## Requirements
- R1: After reset, every output-enable is 0, every output latch bit is 0, both edge enables, the routing register and the status register are 0, and all interrupt outputs are low.
- R2: A read returns the addressed register on `rdata` in the same cycle. Bits 31..28 always read 0. The set and clear strobe addresses (2 and 3) read 0. Routing (address 8) reads back only bits 7..0.
- R3: The level register (address 0) shows the value a pin had two rising clock edges earlier, and not before then.
- R4: A write to address 2 drives high each output whose data bit is 1 from the next cycle on. Bits written as 0 leave their outputs unchanged. The latch reads back at address 1.
- R5: A write to address 3 drives low each output whose data bit is 1. Bits written as 0 leave their outputs unchanged.
- R6: Direction register (address 4) bit n drives `gpio_oe[n]`: 1 makes the pin an output, 0 makes it an input.
- R7: When rising-enable bit n (address 5) is set, a 0-to-1 change of synchronised pin n sets status bit n (address 7) on the edge after the level register shows the change. With the enable clear, the change sets nothing.
- R8: Falling-enable bit n (address 6) does the same for a 1-to-0 change. With both enables set, either edge sets the bit.
- R9: A status bit stays set until software writes a 1 to it at address 7. Written 0 bits are unaffected, and writing 0x0FFFFFFF clears all status bits.
- R10: If an enabled edge and a write-1-to-clear of the same bit arrive in the same cycle, the bit stays set.
- R11: Routing bit k (k = 0..7) set to 1 puts status bit k on `irq_line[k]` and takes it out of the summary. Set to 0, `irq_line[k]` stays low and the bit feeds the summary. Pins 8..27 always feed the summary.
- R12: `irq_summary` is high whenever any status bit not routed to a dedicated line is set. It stays high until the last such bit is cleared, including bits that were set while others were being cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| gpio_in | input | 28 | Pin input levels (asynchronous) |
| gpio_out | output | 28 | Output latch values |
| gpio_oe | output | 28 | Per-pin output enable (direction) |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 4 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| irq_line | output | 8 | Dedicated interrupts for pins 0..7 |
| irq_summary | output | 1 | OR of the non-routed status bits |

## Verification
A corrupted synchroniser or previous-value register shows up as a level readback that arrives a cycle early or late, or as a status bit that appears with no enabled edge. The bench places each check on the exact cycle the requirements predict, so a shift of one cycle is caught. A wrong status update, such as a lost sticky bit, a clear that reaches the wrong bit, or a clear that beats a new edge, shows on the status read and on the interrupt outputs three edges after the pin changes. Routing faults show at once on `irq_line` and `irq_summary`, because these outputs are combinational from status and routing.

// File: rtl/gpio_edge_pkg.sv
package gpio_edge_pkg;
  localparam int unsigned REG_AW = 4;

  typedef enum logic [REG_AW-1:0] {
    ADR_LEVEL  = 4'd0,
    ADR_OUTVAL = 4'd1,
    ADR_SET    = 4'd2,
    ADR_CLR    = 4'd3,
    ADR_DIR    = 4'd4,
    ADR_RISE   = 4'd5,
    ADR_FALL   = 4'd6,
    ADR_STAT   = 4'd7,
    ADR_ROUTE  = 4'd8
  } gpio_adr_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int unsigned W      = 28,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] stg_q [STAGES];

  for (genvar k = 0; k < STAGES; k++) begin : g_stage
    logic [W-1:0] stg_d;
    if (k == 0) begin : g_first
      assign stg_d = din;
    end else begin : g_rest
      assign stg_d = stg_q[k-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg_q[k] <= '0;
      else        stg_q[k] <= stg_d;
    end
  end

  assign dout = stg_q[STAGES-1];
endmodule

// File: rtl/gpio_edge_det.sv
module gpio_edge_det #(
  parameter int unsigned W = 28
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] level,
  input  logic [W-1:0] rise_en,
  input  logic [W-1:0] fall_en,
  input  logic [W-1:0] clr_mask,
  output logic [W-1:0] status
);
  logic [W-1:0] prev_q;
  logic [W-1:0] status_q, status_d;
  logic [W-1:0] hit;

  always_comb begin
    hit      = (level & ~prev_q & rise_en) | (~level & prev_q & fall_en);
    status_d = (status_q & ~clr_mask) | hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q   <= '0;
      status_q <= '0;
    end else begin
      prev_q   <= level;
      status_q <= status_d;
    end
  end

  assign status = status_q;

  AST_EDGE_LATCHES: assert property (@(posedge clk) disable iff (!rst_n)
    (hit != '0) |=> ((status_q & $past(hit)) == $past(hit))); // R10

  AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    ((status_q & $past(status_q & ~clr_mask)) == $past(status_q & ~clr_mask))); // R9
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_edge_pkg::*;
#(
  parameter int unsigned NPINS = 28,
  parameter int unsigned DW    = 32,
  parameter int unsigned NDED  = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_AW-1:0] addr,
  input  logic [NPINS-1:0] wbits,
  input  logic [NPINS-1:0] level,
  input  logic [NPINS-1:0] status,
  output logic [NPINS-1:0] out_q,
  output logic [NPINS-1:0] dir_q,
  output logic [NPINS-1:0] rise_q,
  output logic [NPINS-1:0] fall_q,
  output logic [NDED-1:0]  route_q,
  output logic [NPINS-1:0] clr_mask,
  output logic [DW-1:0]    rdata
);
  logic [NPINS-1:0] out_d, dir_d, rise_d, fall_d;
  logic [NDED-1:0]  route_d;
  logic wr_set, wr_clr, wr_dir, wr_rise, wr_fall, wr_stat, wr_route;

  always_comb begin
    wr_set   = wr_en && (addr == ADR_SET);
    wr_clr   = wr_en && (addr == ADR_CLR);
    wr_dir   = wr_en && (addr == ADR_DIR);
    wr_rise  = wr_en && (addr == ADR_RISE);
    wr_fall  = wr_en && (addr == ADR_FALL);
    wr_stat  = wr_en && (addr == ADR_STAT);
    wr_route = wr_en && (addr == ADR_ROUTE);
  end

  always_comb begin
    out_d   = out_q;
    if (wr_set) out_d = out_q | wbits;
    if (wr_clr) out_d = out_q & ~wbits;
    dir_d   = wr_dir   ? wbits : dir_q;
    rise_d  = wr_rise  ? wbits : rise_q;
    fall_d  = wr_fall  ? wbits : fall_q;
    route_d = wr_route ? wbits[NDED-1:0] : route_q;
    clr_mask = wr_stat ? wbits : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q   <= '0;
      dir_q   <= '0;
      rise_q  <= '0;
      fall_q  <= '0;
      route_q <= '0;
    end else begin
      if (wr_set || wr_clr) out_q <= out_d;
      if (wr_dir)   dir_q   <= dir_d;
      if (wr_rise)  rise_q  <= rise_d;
      if (wr_fall)  fall_q  <= fall_d;
      if (wr_route) route_q <= route_d;
    end
  end

  always_comb begin
    unique case (addr)
      ADR_LEVEL:  rdata = DW'(level);
      ADR_OUTVAL: rdata = DW'(out_q);
      ADR_DIR:    rdata = DW'(dir_q);
      ADR_RISE:   rdata = DW'(rise_q);
      ADR_FALL:   rdata = DW'(fall_q);
      ADR_STAT:   rdata = DW'(status);
      ADR_ROUTE:  rdata = DW'(route_q);
      default:    rdata = '0;
    endcase
  end

  AST_SET_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
    wr_set |=> ((out_q & $past(wbits)) == $past(wbits))); // R4

  AST_CLR_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
    wr_clr |=> ((out_q & $past(wbits)) == '0)); // R5

  AST_OUT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_set || wr_clr) |=> $stable(out_q)); // R4
endmodule

// File: rtl/gpio_irq_route.sv
module gpio_irq_route #(
  parameter int unsigned NPINS = 28,
  parameter int unsigned NDED  = 8
) (
  input  logic [NPINS-1:0] status,
  input  logic [NDED-1:0]  route,
  output logic [NDED-1:0]  irq_line,
  output logic             irq_summary
);
  logic [NPINS-1:0] route_ext;

  for (genvar k = 0; k < NDED; k++) begin : g_ded
    assign irq_line[k] = status[k] & route[k];
  end

  assign route_ext   = NPINS'(route);
  assign irq_summary = |(status & ~route_ext);
endmodule

// File: rtl/gpio_edge_port.sv
module gpio_edge_port
  import gpio_edge_pkg::*;
#(
  parameter int unsigned NPINS       = 28,
  parameter int unsigned DW          = 32,
  parameter int unsigned NDED        = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NPINS-1:0]  gpio_in,
  output logic [NPINS-1:0]  gpio_out,
  output logic [NPINS-1:0]  gpio_oe,
  input  logic              bus_wr,
  input  logic [REG_AW-1:0] bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  output logic [NDED-1:0]   irq_line,
  output logic              irq_summary
);
  logic [NPINS-1:0] level, status, rise_en, fall_en, clr_mask, wbits;
  logic [NDED-1:0]  route;
  logic             unused_wdata_hi;

  assign wbits           = bus_wdata[NPINS-1:0];
  assign unused_wdata_hi = ^bus_wdata[DW-1:NPINS];

  gpio_sync #(.W(NPINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(gpio_in), .dout(level)
  );

  gpio_edge_det #(.W(NPINS)) u_edge (
    .clk(clk), .rst_n(rst_n), .level(level), .rise_en(rise_en),
    .fall_en(fall_en), .clr_mask(clr_mask), .status(status)
  );

  gpio_regs #(.NPINS(NPINS), .DW(DW), .NDED(NDED)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(bus_wr), .addr(bus_addr),
    .wbits(wbits), .level(level), .status(status), .out_q(gpio_out),
    .dir_q(gpio_oe), .rise_q(rise_en), .fall_q(fall_en), .route_q(route),
    .clr_mask(clr_mask), .rdata(bus_rdata)
  );

  gpio_irq_route #(.NPINS(NPINS), .NDED(NDED)) u_route (
    .status(status), .route(route), .irq_line(irq_line),
    .irq_summary(irq_summary)
  );

  AST_SUMMARY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_summary && !bus_wr) |=> irq_summary); // R12

  AST_LINE_NEEDS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    ((irq_line & ~status[NDED-1:0]) == '0)); // R11
endmodule

// File: tb/gpio_edge_port_bench.sv
`timescale 1ns/1ps
module gpio_edge_port_bench;
  localparam int NP = 28;
  localparam logic [31:0] ALL = 32'h0FFF_FFFF;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [27:0] gpio_in;
  logic [27:0] gpio_out, gpio_oe;
  logic        bus_wr;
  logic [3:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic [7:0]  irq_line;
  logic        irq_summary;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  gpio_edge_port u_gpio_edge_port (
    .clk(clk), .rst_n(rst_n), .gpio_in(gpio_in), .gpio_out(gpio_out),
    .gpio_oe(gpio_oe), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_line(irq_line),
    .irq_summary(irq_summary)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] v);
    @(negedge clk);
    bus_addr = a;
    #1 v = bus_rdata;
  endtask

  task automatic pins(input logic [27:0] v);
    @(negedge clk);
    gpio_in = v;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, model, expst;
    rst_n = 1'b0; gpio_in = '0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    chk("R1 oe", {4'h0, gpio_oe}, 32'h0);
    chk("R1 out", {4'h0, gpio_out}, 32'h0);
    chk("R1 irq", {23'h0, irq_summary, irq_line}, 32'h0);
    for (int a = 0; a < 9; a++) begin
      rd(a[3:0], v); chk("R1 reg", v, 32'h0);
    end

    // R2 readback widths
    wr(4'd4, 32'hFFFF_FFFF); rd(4'd4, v); chk("R2 dir upper zero", v, ALL);
    wr(4'd8, 32'hFFFF_FFFF); rd(4'd8, v); chk("R2 route width", v, 32'h0000_00FF);
    wr(4'd8, 32'h0);
    wr(4'd2, 32'hFFFF_FFFF); rd(4'd2, v); chk("R2 set reads 0", v, 32'h0);
    rd(4'd3, v); chk("R2 clr reads 0", v, 32'h0);
    rd(4'd1, v); chk("R2 outval upper zero", v, ALL);
    wr(4'd3, 32'hFFFF_FFFF);

    // R6 direction sweep
    for (int i = 0; i < NP; i++) begin
      wr(4'd4, 32'h1 << i);
      chk("R6 oe walk", {4'h0, gpio_oe}, 32'h1 << i);
    end
    wr(4'd4, 32'h0A5A_5A5A); chk("R6 oe pattern", {4'h0, gpio_oe}, 32'h0A5A_5A5A);
    wr(4'd4, 32'h0); chk("R6 all inputs", {4'h0, gpio_oe}, 32'h0);

    // R4 / R5 set and clear sweep
    model = 0;
    for (int i = 0; i < NP; i++) begin
      wr(4'd2, 32'h1 << i); model |= 32'h1 << i;
      chk("R4 set walk", {4'h0, gpio_out}, model);
      wr(4'd2, 32'h0); chk("R4 zero no effect", {4'h0, gpio_out}, model);
    end
    for (int i = 0; i < NP; i += 2) begin
      wr(4'd3, 32'h1 << i); model &= ~(32'h1 << i);
      chk("R5 clr walk", {4'h0, gpio_out}, model);
    end
    wr(4'd3, 32'h0); chk("R5 zero no effect", {4'h0, gpio_out}, model);
    rd(4'd1, v); chk("R4 outval read", v, model);
    wr(4'd3, ALL); chk("R5 clear all", {4'h0, gpio_out}, 32'h0);

    // R3 level latency and sweep
    @(negedge clk); gpio_in = 28'h5A5_A5A5;
    @(negedge clk); bus_addr = 4'd0; #0.5 chk("R3 not after one edge", bus_rdata, 32'h0);
    @(negedge clk); #0.5 chk("R3 after two edges", bus_rdata, 32'h05A5_A5A5);
    for (int i = 0; i < NP; i++) begin
      pins(28'h1 << i); rd(4'd0, v); chk("R3 level walk", v, 32'h1 << i);
    end
    pins(28'h0); rd(4'd7, v); chk("R7 no enable no status", v, 32'h0);

    // R7 / R8 / R9 per-pin edge sweep over enable modes
    for (int i = 0; i < NP; i++) begin
      for (int m = 0; m < 4; m++) begin
        wr(4'd5, m[0] ? (32'h1 << i) : 32'h0);
        wr(4'd6, m[1] ? (32'h1 << i) : 32'h0);
        wr(4'd7, ALL);
        pins(28'h1 << i);
        expst = m[0] ? (32'h1 << i) : 32'h0;
        rd(4'd7, v); chk("R7 rising", v, expst);
        pins(28'h0);
        if (m[1]) expst |= 32'h1 << i;
        rd(4'd7, v); chk("R8 falling sticky", v, expst);
        chk("R12 summary", {31'h0, irq_summary}, {31'h0, expst != 0});
      end
    end

    // R9 selective clear
    wr(4'd5, ALL); wr(4'd6, 32'h0); wr(4'd7, ALL);
    pins(28'hFFF_FFFF);
    rd(4'd7, v); chk("R9 all set", v, ALL);
    wr(4'd7, 32'h0); rd(4'd7, v); chk("R9 zero write keeps", v, ALL);
    wr(4'd7, 32'h0000_F00F); rd(4'd7, v); chk("R9 partial clear", v, ALL & ~32'h0000_F00F);
    wr(4'd7, ALL); rd(4'd7, v); chk("R9 clear all", v, 32'h0);
    pins(28'h0);

    // R10 edge coincides with clear
    wr(4'd5, 32'h0000_0010); wr(4'd7, ALL);
    @(negedge clk); gpio_in = 28'h10;
    @(negedge clk);
    @(negedge clk); bus_wr = 1'b1; bus_addr = 4'd7; bus_wdata = 32'h10;
    @(negedge clk); bus_wr = 1'b0; bus_wdata = 0;
    rd(4'd7, v); chk("R10 edge wins", v, 32'h10);
    wr(4'd7, 32'h10); rd(4'd7, v); chk("R10 later clear", v, 32'h0);
    pins(28'h0);

    // R11 routing sweep
    wr(4'd5, ALL); wr(4'd6, 32'h0);
    for (int k = 0; k < 8; k++) begin
      wr(4'd8, 32'h1 << k); wr(4'd7, ALL);
      pins((28'h1 << k) | (28'h1 << 20));
      chk("R11 line routed", {24'h0, irq_line}, 32'h1 << k);
      chk("R11 summary from pin 20", {31'h0, irq_summary}, 32'h1);
      wr(4'd7, 32'h1 << 20);
      chk("R11 routed bit not in summary", {31'h0, irq_summary}, 32'h0);
      chk("R11 line held", {24'h0, irq_line}, 32'h1 << k);
      wr(4'd8, 32'h0);
      chk("R11 unrouted line low", {24'h0, irq_line}, 32'h0);
      chk("R11 unrouted feeds summary", {31'h0, irq_summary}, 32'h1);
      wr(4'd7, 32'h1 << k);
      chk("R11 cleared", {23'h0, irq_summary, irq_line}, 32'h0);
      pins(28'h0);
    end

    // R12 summary held across servicing
    wr(4'd8, 32'h0); wr(4'd7, ALL);
    pins(28'h0000208);
    chk("R12 two set", {31'h0, irq_summary}, 32'h1);
    wr(4'd7, 32'h8); chk("R12 one left", {31'h0, irq_summary}, 32'h1);
    pins(28'h0008208);
    wr(4'd7, 32'h200); chk("R12 new bit holds", {31'h0, irq_summary}, 32'h1);
    wr(4'd7, 32'h8000); chk("R12 last cleared", {31'h0, irq_summary}, 32'h0);
    pins(28'h0);

    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule